// File: doc/BRIEF.md
# Boot Download Entry Controller

After every reset this block chooses one of two paths. The device either enters its serial downloader or hands control to user code. The choice depends on three things: the level of a boot-mode pin, a 16-bit millisecond timeout word held in nonvolatile storage, and the first frame that an I2C slave front end reports.

The front end is modelled as single-cycle events: an address byte was received (with the address and the direction bit), a data byte was received, and a stop condition was seen. A 1 ms tick paces both timers. In download mode the block also watches for a long silence on the bus and issues a software reset when that silence runs too long.

Each decision produces exactly one single-cycle pulse: enter downloader, exit to user code, or software reset. The block then stays idle until the next reset.

Top module: `boot_entry_ctrl`

## Requirements
- R1: When `boot_pin` is high at the first clock after reset release, `exit_user` pulses on that clock edge. No timeout is waited for and no frame is waited for.
- R2: When `boot_pin` is low, the block waits for a frame. With a timeout word N (not 0xFFFE), `exit_user` pulses on the edge that registers the N-th `ms_tick`, provided no frame has started.
- R3: `enter_dl` pulses on the edge that registers a stop, but only when the first frame was a write (`ev_rnw`=0) to address 0x04 that carried exactly one data byte of 0x08.
- R4: Any other first frame makes `exit_user` pulse on the edge that registers its stop. This covers a different address, a read, zero bytes, two or more bytes, and a byte other than 0x08.
- R5: A timeout word of 0xFFFF gives a wait of 65535 ticks. The word 0xFFFE selects the long window of `LONG_MS` ticks (900000 by default).
- R6: In download mode, `soft_reset` pulses on the edge that registers the `LONG_MS`-th tick with no valid frame in between. A valid frame is a write to 0x04 with at least one data byte, ended by a stop, and it restarts that count.
- R7: `addr_ack` is high in the same cycle as `ev_start` whenever `ev_addr` equals 0x04 and the block is waiting or in download mode. This holds even when the frame's content will not match the entry pattern. It is low otherwise.
- R8: At most one of `enter_dl`, `exit_user` and `soft_reset` is high in any cycle. After an `exit_user` or `soft_reset` pulse, no output pulses again until reset.
- R9: Ticks that arrive while a first frame is in progress do not expire the wait timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_pin | input | 1 | Boot-mode pin level; high means go straight to user code |
| tmo_word | input | 16 | Stored wait time in ms; 0xFFFE selects the long window |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| ev_start | input | 1 | Address byte received |
| ev_addr | input | 7 | 7-bit address from the address byte |
| ev_rnw | input | 1 | Direction bit of the address byte (1 = read) |
| ev_byte | input | 1 | Data byte received |
| ev_data | input | 8 | Value of the data byte |
| ev_stop | input | 1 | Stop condition seen |
| addr_ack | output | 1 | Acknowledge the address byte |
| enter_dl | output | 1 | Pulse: enter the downloader |
| exit_user | output | 1 | Pulse: hand control to user code |
| soft_reset | output | 1 | Pulse: idle window in download mode ran out |

## Verification
Every decision pulse is registered, so it appears one clock after the edge that registers its cause. That cause is the first clock after reset release, the stop event, or the final tick. The acknowledge is combinational and is due within the `ev_start` cycle itself.

The bench's driver notes the cycle number when it drives the stimulus that should cause a decision, adds one, and queues that value with the expected pulse. The monitor samples on the falling edge and requires every pulse to match the queue head in both kind and cycle. Any pulse with no matching entry counts as a failure. The acknowledge is checked mid-cycle, right after the event is driven.

// File: rtl/boot_entry_pkg.sv
package boot_entry_pkg;

  localparam int MS_W = 20;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_WAIT = 2'd1,
    ST_DL   = 2'd2,
    ST_DONE = 2'd3
  } be_state_t;

  // Wait limit in ticks: the special code picks the long window.
  function automatic logic [MS_W-1:0] wait_limit(input logic [15:0] word,
                                                 input logic [MS_W-1:0] long_ms);
    if (word == 16'hFFFE) return long_ms;
    return MS_W'(word);
  endfunction

  // Entry pattern: matched write, one byte exactly, the right value.
  function automatic logic entry_match(input logic hit, input logic [1:0] nbytes,
                                       input logic [7:0] first, input logic [7:0] pattern);
    return hit && (nbytes == 2'd1) && (first == pattern);
  endfunction

endpackage

// File: rtl/boot_frame_tracker.sv
module boot_frame_tracker #(
  parameter logic [6:0] NODE = 7'h04
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic [6:0] ev_addr,
  input  logic       ev_rnw,
  input  logic       ev_byte,
  input  logic [7:0] ev_data,
  input  logic       ev_stop,
  output logic       active,
  output logic       done,
  output logic       hit,
  output logic [1:0] nbytes,
  output logic [7:0] first
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      hit    <= 1'b0;
      nbytes <= 2'd0;
      first  <= 8'h00;
    end else if (ev_start) begin
      active <= 1'b1;
      hit    <= (ev_addr == NODE) && !ev_rnw;
      nbytes <= 2'd0;
    end else if (ev_stop) begin
      active <= 1'b0;
    end else if (ev_byte && active) begin
      if (nbytes == 2'd0) first <= ev_data;
      if (nbytes != 2'd2) nbytes <= nbytes + 2'd1;
    end
  end

  assign done = ev_stop && active;

endmodule

// File: rtl/boot_ms_timer.sv
module boot_ms_timer #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         expired
);

  logic [W-1:0] cnt;
  logic [W:0]   cnt_nx;

  assign cnt_nx  = {1'b0, cnt} + 1'b1;
  assign expired = run && tick && !clr && (cnt_nx >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (clr)                      cnt <= '0;
    else if (run && tick && !expired)  cnt <= cnt_nx[W-1:0];
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    run && !clr && (limit != '0) |-> cnt < limit); // R2

endmodule

// File: rtl/boot_entry_ctrl.sv
module boot_entry_ctrl
  import boot_entry_pkg::*;
#(
  parameter logic [6:0]      NODE_ADDR = 7'h04,
  parameter logic [7:0]      ENTRY_BYTE = 8'h08,
  parameter logic [MS_W-1:0] LONG_MS   = MS_W'(900000)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_pin,
  input  logic [15:0] tmo_word,
  input  logic        ms_tick,
  input  logic        ev_start,
  input  logic [6:0]  ev_addr,
  input  logic        ev_rnw,
  input  logic        ev_byte,
  input  logic [7:0]  ev_data,
  input  logic        ev_stop,
  output logic        addr_ack,
  output logic        enter_dl,
  output logic        exit_user,
  output logic        soft_reset
);

  be_state_t       state;
  logic            fr_active, fr_done, fr_hit;
  logic [1:0]      fr_nbytes;
  logic [7:0]      fr_first;
  logic            wait_exp, idle_exp, valid_frame, is_entry;
  logic [MS_W-1:0] wait_lim;

  boot_frame_tracker #(.NODE(NODE_ADDR)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .ev_start(ev_start), .ev_addr(ev_addr), .ev_rnw(ev_rnw),
    .ev_byte(ev_byte), .ev_data(ev_data), .ev_stop(ev_stop),
    .active(fr_active), .done(fr_done), .hit(fr_hit),
    .nbytes(fr_nbytes), .first(fr_first)
  );

  assign wait_lim    = wait_limit(tmo_word, LONG_MS);
  assign is_entry    = entry_match(fr_hit, fr_nbytes, fr_first, ENTRY_BYTE);
  assign valid_frame = fr_done && fr_hit && (fr_nbytes != 2'd0);

  boot_ms_timer #(.W(MS_W)) u_wait (
    .clk(clk), .rst_n(rst_n),
    .clr(state != ST_WAIT), .run(!fr_active), .tick(ms_tick),
    .limit(wait_lim), .expired(wait_exp)
  );

  boot_ms_timer #(.W(MS_W)) u_idle (
    .clk(clk), .rst_n(rst_n),
    .clr((state != ST_DL) || valid_frame), .run(1'b1), .tick(ms_tick),
    .limit(LONG_MS), .expired(idle_exp)
  );

  assign addr_ack = ev_start && (ev_addr == NODE_ADDR) &&
                    ((state == ST_WAIT) || (state == ST_DL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_INIT;
      enter_dl   <= 1'b0;
      exit_user  <= 1'b0;
      soft_reset <= 1'b0;
    end else begin
      enter_dl   <= 1'b0;
      exit_user  <= 1'b0;
      soft_reset <= 1'b0;
      unique case (state)
        ST_INIT: begin
          if (boot_pin) begin
            exit_user <= 1'b1;
            state     <= ST_DONE;
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (fr_done) begin
            if (is_entry) begin
              enter_dl <= 1'b1;
              state    <= ST_DL;
            end else begin
              exit_user <= 1'b1;
              state     <= ST_DONE;
            end
          end else if (wait_exp) begin
            exit_user <= 1'b1;
            state     <= ST_DONE;
          end
        end
        ST_DL: begin
          if (idle_exp) begin
            soft_reset <= 1'b1;
            state      <= ST_DONE;
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({enter_dl, exit_user, soft_reset}) <= 1); // R8
  AST_PIN_HIGH_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INIT) && boot_pin |=> exit_user); // R1
  AST_ENTER_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    enter_dl |-> $past(state == ST_WAIT) && (state == ST_DL)); // R3
  AST_RESET_FROM_DL: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |-> $past(state == ST_DL)); // R6
  AST_TERMINAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> (state == ST_DONE) && !enter_dl && !soft_reset); // R8
  AST_ACK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack |-> ev_start && (ev_addr == NODE_ADDR)); // R7

endmodule

// File: tb/tb_boot_entry_ctrl.sv
module tb_boot_entry_ctrl;

  localparam int LONG = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_pin = 1'b0;
  logic [15:0] tmo_word = 16'd5;
  logic        ms_tick = 1'b0;
  logic        ev_start = 1'b0;
  logic [6:0]  ev_addr = 7'h00;
  logic        ev_rnw = 1'b0;
  logic        ev_byte = 1'b0;
  logic [7:0]  ev_data = 8'h00;
  logic        ev_stop = 1'b0;
  logic        addr_ack, enter_dl, exit_user, soft_reset;

  boot_entry_ctrl #(.LONG_MS(20'(LONG))) dut (
    .clk(clk), .rst_n(rst_n), .boot_pin(boot_pin), .tmo_word(tmo_word),
    .ms_tick(ms_tick), .ev_start(ev_start), .ev_addr(ev_addr), .ev_rnw(ev_rnw),
    .ev_byte(ev_byte), .ev_data(ev_data), .ev_stop(ev_stop),
    .addr_ack(addr_ack), .enter_dl(enter_dl), .exit_user(exit_user),
    .soft_reset(soft_reset)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // kind: 1 enter, 2 exit, 3 reset
  typedef struct { int kind; int at; string req; } exp_t;
  exp_t q[$];

  task automatic expect_ev(input int kind, input string req);
    exp_t e;
    e.kind = kind; e.at = cyc + 1; e.req = req;
    q.push_back(e);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: every pulse must match the head of the queue.
  always @(negedge clk) begin
    if (rst_n && (enter_dl || exit_user || soft_reset)) begin
      automatic int k = enter_dl ? 1 : exit_user ? 2 : 3;
      if (q.size() == 0) begin
        check(1'b0, "R8 unexpected pulse", k, 0);
      end else begin
        automatic exp_t e = q.pop_front();
        check((k == e.kind) && (cyc == e.at), {e.req, " kind*1000+cycle"},
              k * 1000 + cyc, e.kind * 1000 + e.at);
      end
    end
  end

  task automatic do_reset(input bit pin, input logic [15:0] word);
    @(negedge clk);
    check(q.size() == 0, "R8 missing pulse before reset", q.size(), 0);
    q.delete();
    rst_n = 1'b0; boot_pin = pin; tmo_word = word;
    repeat (3) @(negedge clk);
    check(!enter_dl && !exit_user && !soft_reset, "R8 reset state quiet",
          {enter_dl, exit_user, soft_reset}, 0);
    rst_n = 1'b1;
  endtask

  task automatic ticks(input int n, input int exp_kind, input string req);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      ms_tick = 1'b1;
      if (i == n && exp_kind != 0) expect_ev(exp_kind, req);
    end
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  task automatic frame(input logic [6:0] a, input bit rnw, input int nb,
                       input logic [7:0] d0, input logic [7:0] d1,
                       input bit ack_exp, input int exp_kind, input string req);
    @(negedge clk);
    ev_start = 1'b1; ev_addr = a; ev_rnw = rnw;
    #2 check(addr_ack == ack_exp, "R7 address acknowledge", addr_ack, ack_exp);
    @(negedge clk);
    ev_start = 1'b0;
    for (int i = 0; i < nb; i++) begin
      ev_byte = 1'b1; ev_data = (i == 0) ? d0 : d1;
      @(negedge clk);
      ev_byte = 1'b0;
    end
    ev_stop = 1'b1;
    if (exp_kind != 0) expect_ev(exp_kind, req);
    @(negedge clk);
    ev_stop = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: pin high exits on the first clock
    do_reset(1'b1, 16'd5);
    expect_ev(2, "R1 pin high exit");
    settle(2);
    // R8: terminal state ignores an entry frame and ticks
    frame(7'h04, 1'b0, 1, 8'h08, 8'h00, 1'b0, 0, "R8");
    ticks(10, 0, "R8");

    // R2: timeout after N ticks
    do_reset(1'b0, 16'd5);
    settle(1);
    ticks(5, 2, "R2 timeout exit");

    // R2: zero word expires on the first tick
    do_reset(1'b0, 16'd0);
    settle(1);
    ticks(1, 2, "R2 zero timeout");

    // R3: entry pattern, then R6 idle reset
    do_reset(1'b0, 16'd50);
    settle(1);
    ticks(3, 0, "R3");
    frame(7'h04, 1'b0, 1, 8'h08, 8'h00, 1'b1, 1, "R3 entry");
    ticks(30, 0, "R6");
    frame(7'h04, 1'b0, 1, 8'h57, 8'h00, 1'b1, 0, "R6");
    frame(7'h11, 1'b0, 1, 8'h57, 8'h00, 1'b0, 0, "R7");
    ticks(LONG, 3, "R6 idle reset");
    settle(3);

    // R4: wrong byte, two bytes, zero bytes, read, other address
    do_reset(1'b0, 16'd50);
    settle(1);
    frame(7'h04, 1'b0, 1, 8'h09, 8'h00, 1'b1, 2, "R4 wrong byte");
    do_reset(1'b0, 16'd50);
    settle(1);
    frame(7'h04, 1'b0, 2, 8'h08, 8'h08, 1'b1, 2, "R4 two bytes");
    do_reset(1'b0, 16'd50);
    settle(1);
    frame(7'h04, 1'b0, 0, 8'h08, 8'h00, 1'b1, 2, "R4 no bytes");
    do_reset(1'b0, 16'd50);
    settle(1);
    frame(7'h04, 1'b1, 1, 8'h08, 8'h00, 1'b1, 2, "R4 read frame");
    do_reset(1'b0, 16'd50);
    settle(1);
    frame(7'h05, 1'b0, 1, 8'h08, 8'h00, 1'b0, 2, "R4 other address");

    // R9: ticks during a frame do not expire the wait
    do_reset(1'b0, 16'd5);
    settle(1);
    ticks(3, 0, "R9");
    @(negedge clk);
    ev_start = 1'b1; ev_addr = 7'h04; ev_rnw = 1'b0;
    @(negedge clk);
    ev_start = 1'b0; ev_byte = 1'b1; ev_data = 8'h08;
    @(negedge clk);
    ev_byte = 1'b0;
    ticks(10, 0, "R9");
    ev_stop = 1'b1;
    expect_ev(1, "R9 entry after long frame");
    @(negedge clk);
    ev_stop = 1'b0;
    settle(2);

    // R5: special code and erased word
    do_reset(1'b0, 16'hFFFE);
    settle(1);
    ticks(LONG, 2, "R5 long window code");
    do_reset(1'b0, 16'hFFFF);
    settle(1);
    ticks(65535, 2, "R5 erased word");
    settle(2);
    check(q.size() == 0, "R8 missing pulse at end", q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule